// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block performs the exception entry and exception return sequences of a small 16-bit processor. It owns the program counter, the stack pointer and the 8-bit condition-code register. It reaches memory through a single word-wide port. Instruction fetch and decode sit elsewhere. The surrounding core only raises a pending-interrupt request with a vector number, raises a return request, or loads one of the three registers.

On entry the sequencer masks further interrupts at once. It then pushes the program counter and the condition-code byte onto a stack that grows downward. The condition-code byte is copied into both halves of its stack word. The handler address is found through two reads: the vector-table slot holds a pointer, and the word at that pointer is the handler. The return sequence pops the condition-code word first and then the program counter, in the reverse order of the pushes. Bit 7 of the condition-code register is a mask: when it is 1, interrupts are disabled.

Memory addresses are byte addresses, and every transfer is one word at an even address. A word is stored big-endian, with its high byte at the even address. Read data appears on `mem_rdata` in the cycle after the cycle in which `mem_req` is high with `mem_we` low. It stays valid until the next request.

Top module: `exc_sequencer`

## Requirements
- R1: After reset, `pc_o`=0x0000, `sp_o`=0x0000, `ccr_o`=0x80, and `busy`, `done` and `mem_req` are all 0.
- R2: An entry starts only when the block is idle, `irq_req`=1 and `ccr_o` bit 7=0. A request seen while bit 7=1 leaves `busy`, `pc_o`, `sp_o` and `ccr_o` unchanged.
- R3: On the cycle after an entry is accepted, `ccr_o` bit 7 reads 1. Bits 6..0 keep their values (C=bit 0, V=bit 1, Z=bit 2, N=bit 3).
- R4: Entry writes the program counter at SP-2, then writes {ccr,ccr} at SP-4. The stacked byte is the condition-code value from before entry, so its bit 7 is 0. `sp_o` ends at SP-4.
- R5: The slot address is the vector number shifted left by one. The word read there is a pointer, and the word read at that pointer is loaded into `pc_o`.
- R6: Return reads the word at SP and loads its low byte into `ccr_o`, including bit 7. It then reads the word at SP+2 into `pc_o`. `sp_o` ends at SP+4.
- R7: `busy` is 1 while a sequence runs. `done` is a single-cycle pulse that marks the end of each sequence.
- R8: While `busy`=1, `irq_req`, `ret_req` and register loads have no effect.
- R9: When the block is idle and entry and return are requested in the same cycle, the entry is taken.
- R10: Bit 0 is forced to 0 in every stack pointer value, every loaded or popped program counter, the vector pointer and the handler address. Every `mem_addr` is even.
- R11: When idle, `ld_en` loads `ld_data` into a register chosen by `ld_sel`: 0 selects the PC, 1 the SP, 2 the CCR (low byte). Code 3 loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt pending |
| irq_vec | input | VW | Vector number of the pending interrupt |
| ret_req | input | 1 | Start return-from-exception |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Load target: 0 PC, 1 SP, 2 CCR, 3 none |
| ld_data | input | DW | Load value |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | DW | Byte address, always even |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| pc_o | output | DW | Program counter |
| sp_o | output | DW | Stack pointer |
| ccr_o | output | 8 | Condition-code register, bit 7 = interrupt mask |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | End-of-sequence pulse |

## Verification
A wrong state step appears at the memory port within one or two cycles. It can show as a push at the wrong address, a missing duplicate of the flag byte, or a read issued at the slot instead of the pointer. A fault in the register update first appears on `pc_o`, `sp_o` and `ccr_o` once `done` pulses. A full entry followed by a return must bring all three registers back to their values from before the entry, so one round trip exposes most mistakes. The slot pointer is odd in the bench, which shows whether the pointer is aligned before it is dereferenced.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, EN_CC, EN_SLOT, EN_SW, EN_PTR, EN_PW, EN_LD,
    RT_W1, RT_CC, RT_W2, RT_PC
  } seq_state_e;

  localparam int MASK_BIT = 7;
  localparam logic [1:0] SEL_PC  = 2'd0;
  localparam logic [1:0] SEL_SP  = 2'd1;
  localparam logic [1:0] SEL_CCR = 2'd2;
  localparam logic [7:0] CCR_RESET = 8'h80;
endpackage

// File: rtl/exc_stack_ptr.sv
module exc_stack_ptr #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_val,
  input  logic          dec,
  input  logic          inc,
  output logic [DW-1:0] sp
);
  localparam logic [DW-1:0] STEP = DW'(2);

  always_ff @(posedge clk) begin
    if (rst)        sp <= '0;
    else if (ld_en) sp <= {ld_val[DW-1:1], 1'b0};
    else if (dec)   sp <= sp - STEP;
    else if (inc)   sp <= sp + STEP;
  end

  // R6
  sp_no_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    !(dec && inc) && !(ld_en && (dec || inc)));
endmodule

// File: rtl/exc_ccr_reg.sv
module exc_ccr_reg
  import exc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mask_set,
  input  logic       restore_en,
  input  logic [7:0] restore_val,
  input  logic       ld_en,
  input  logic [7:0] ld_val,
  output logic [7:0] ccr
);
  always_ff @(posedge clk) begin
    if (rst)             ccr <= CCR_RESET;
    else if (mask_set)   ccr[MASK_BIT] <= 1'b1;
    else if (restore_en) ccr <= restore_val;
    else if (ld_en)      ccr <= ld_val;
  end

  // R3
  mask_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
    mask_set |=> (ccr[MASK_BIT] && ccr[6:0] == $past(ccr[6:0])));
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_req,
  input  logic [VW-1:0] irq_vec,
  input  logic          ret_req,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [DW-1:0] ld_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] sp_o,
  output logic [7:0]    ccr_o,
  output logic          busy,
  output logic          done
);
  localparam int PAD = DW - VW - 1;
  localparam logic [DW-1:0] STEP = DW'(2);

  seq_state_e    state;
  logic [VW-1:0] vec_q;
  logic [7:0]    ccr_saved;
  logic          accept_irq, accept_ret, idle, ld_ok;
  logic          sp_dec, sp_inc;
  logic [DW-1:0] aligned_rd;

  assign idle       = (state == ST_IDLE);
  assign accept_irq = idle && irq_req && !ccr_o[MASK_BIT];
  assign accept_ret = idle && ret_req && !accept_irq;
  assign ld_ok      = idle && ld_en && !accept_irq && !accept_ret;
  assign sp_dec     = accept_irq || (state == EN_CC);
  assign sp_inc     = accept_ret || (state == RT_CC);
  assign aligned_rd = {mem_rdata[DW-1:1], 1'b0};
  assign busy       = !idle;

  exc_stack_ptr #(.DW(DW)) sp_i (
    .clk(clk), .rst(rst),
    .ld_en(ld_ok && ld_sel == SEL_SP), .ld_val(ld_data),
    .dec(sp_dec), .inc(sp_inc), .sp(sp_o)
  );

  exc_ccr_reg ccr_i (
    .clk(clk), .rst(rst),
    .mask_set(accept_irq),
    .restore_en(state == RT_CC), .restore_val(mem_rdata[7:0]),
    .ld_en(ld_ok && ld_sel == SEL_CCR), .ld_val(ld_data[7:0]),
    .ccr(ccr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      vec_q     <= '0;
      ccr_saved <= '0;
      pc_o      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept_irq) begin
            vec_q     <= irq_vec;
            ccr_saved <= ccr_o;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= sp_o - STEP;
            mem_wdata <= pc_o;
            state     <= EN_CC;
          end else if (accept_ret) begin
            mem_req  <= 1'b1;
            mem_addr <= sp_o;
            state    <= RT_W1;
          end else if (ld_ok && ld_sel == SEL_PC) begin
            pc_o <= {ld_data[DW-1:1], 1'b0};
          end
        end
        EN_CC: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= sp_o - STEP;
          mem_wdata <= {{(DW-16){1'b0}}, ccr_saved, ccr_saved};
          state     <= EN_SLOT;
        end
        EN_SLOT: begin
          mem_req  <= 1'b1;
          mem_addr <= {{PAD{1'b0}}, vec_q, 1'b0};
          state    <= EN_SW;
        end
        EN_SW:  state <= EN_PTR;
        EN_PTR: begin
          mem_req  <= 1'b1;
          mem_addr <= aligned_rd;
          state    <= EN_PW;
        end
        EN_PW:  state <= EN_LD;
        EN_LD: begin
          pc_o  <= aligned_rd;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        RT_W1:  state <= RT_CC;
        RT_CC: begin
          mem_req  <= 1'b1;
          mem_addr <= sp_o;
          state    <= RT_W2;
        end
        RT_W2:  state <= RT_PC;
        RT_PC: begin
          pc_o  <= aligned_rd;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  mem_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]);

  // R4
  push_at_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr == sp_o));

  // R4
  ccr_dup_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && $past(mem_req && mem_we)) |->
      (mem_wdata[15:8] == mem_wdata[7:0] && !mem_wdata[MASK_BIT]));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  entry_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && irq_req && !ccr_o[MASK_BIT]) |=> (busy && mem_req && mem_we));
endmodule

// File: tb/exc_sequencer_tb.sv
module exc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0;
  logic [7:0]  irq_vec = '0;
  logic        ret_req = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [15:0] ld_data = '0;
  logic        mem_req, mem_we, busy, done;
  logic [15:0] mem_addr, mem_wdata, pc_o, sp_o;
  logic [15:0] mem_rdata = '0;
  logic [7:0]  ccr_o;
  logic [15:0] mem [0:1023];
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  exc_sequencer dut_i (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
    .ret_req(ret_req), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_o(pc_o),
    .sp_o(sp_o), .ccr_o(ccr_o), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[10:1]] <= mem_wdata;
    else if (mem_req)      mem_rdata <= mem[mem_addr[10:1]];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [15:0] val);
    ld_en = 1'b1; ld_sel = sel; ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, {tag, " R7 done seen"}, seen, 1);
    @(negedge clk);
    chk(!done && !busy, {tag, " R7 done single pulse"}, done, 0);
  endtask

  task automatic do_irq(input logic [7:0] v);
    irq_req = 1'b1; irq_vec = v;
    @(negedge clk);
    irq_req = 1'b0;
    wait_done("irq");
  endtask

  task automatic do_ret();
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done("ret");
  endtask

  task automatic t_reset();
    chk(pc_o == 16'h0 && sp_o == 16'h0, "R1 pc/sp reset", {pc_o, sp_o}, 0);
    chk(ccr_o == 8'h80, "R1 ccr reset", ccr_o, 8'h80);
    chk(!busy && !done && !mem_req, "R1 idle outputs", {busy, done, mem_req}, 0);
  endtask

  task automatic t_loads();
    load(2'd1, 16'h0401);
    chk(sp_o == 16'h0400, "R10 R11 sp load aligned", sp_o, 16'h0400);
    load(2'd0, 16'h1235);
    chk(pc_o == 16'h1234, "R10 R11 pc load aligned", pc_o, 16'h1234);
    load(2'd2, 16'h0005);
    chk(ccr_o == 8'h05, "R11 ccr load", ccr_o, 8'h05);
    load(2'd3, 16'hFFFF);
    chk(pc_o == 16'h1234 && sp_o == 16'h0400 && ccr_o == 8'h05,
        "R11 sel 3 loads nothing", pc_o, 16'h1234);
  endtask

  task automatic t_entry();
    do_irq(8'd3);
    chk(pc_o == 16'h0ABC, "R5 R10 handler via pointer", pc_o, 16'h0ABC);
    chk(sp_o == 16'h03FC, "R4 sp after entry", sp_o, 16'h03FC);
    chk(ccr_o == 8'h85, "R3 mask set flags kept", ccr_o, 8'h85);
    chk(mem[16'h03FE >> 1] == 16'h1234, "R4 pc stacked", mem[16'h03FE >> 1], 16'h1234);
    chk(mem[16'h03FC >> 1] == 16'h0505, "R4 ccr duplicated", mem[16'h03FC >> 1], 16'h0505);
  endtask

  task automatic t_masked();
    irq_req = 1'b1; irq_vec = 8'd5;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!busy, "R2 masked request ignored", busy, 0);
    end
    irq_req = 1'b0;
    chk(pc_o == 16'h0ABC && sp_o == 16'h03FC && ccr_o == 8'h85,
        "R2 registers unchanged", pc_o, 16'h0ABC);
  endtask

  task automatic t_return(input logic [7:0] exp_ccr);
    do_ret();
    chk(ccr_o == exp_ccr, "R6 ccr restored", ccr_o, exp_ccr);
    chk(pc_o == 16'h1234, "R6 pc restored", pc_o, 16'h1234);
    chk(sp_o == 16'h0400, "R6 sp restored", sp_o, 16'h0400);
  endtask

  task automatic t_busy_ignore();
    irq_req = 1'b1; irq_vec = 8'd3;
    @(negedge clk);
    chk(busy, "R7 busy during entry", busy, 1);
    irq_vec = 8'd5; ret_req = 1'b1;
    ld_en = 1'b1; ld_sel = 2'd1; ld_data = 16'h0200;
    @(negedge clk);
    @(negedge clk);
    irq_req = 1'b0; ret_req = 1'b0; ld_en = 1'b0;
    wait_done("busy");
    chk(pc_o == 16'h0ABC, "R8 second vector ignored", pc_o, 16'h0ABC);
    chk(sp_o == 16'h03FC, "R8 load and return ignored", sp_o, 16'h03FC);
  endtask

  task automatic t_priority();
    load(2'd2, 16'h000F);
    irq_req = 1'b1; irq_vec = 8'd5; ret_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0; ret_req = 1'b0;
    wait_done("prio");
    chk(pc_o == 16'h0C00, "R9 entry wins", pc_o, 16'h0C00);
    chk(sp_o == 16'h03FC, "R9 sp moved down", sp_o, 16'h03FC);
    chk(mem[16'h03FC >> 1] == 16'h0F0F, "R4 all flags duplicated",
        mem[16'h03FC >> 1], 16'h0F0F);
    chk(ccr_o == 8'h8F, "R3 flags kept with mask", ccr_o, 8'h8F);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem[16'h0006 >> 1] = 16'h0101;
    mem[16'h0100 >> 1] = 16'h0ABD;
    mem[16'h000A >> 1] = 16'h0120;
    mem[16'h0120 >> 1] = 16'h0C00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_loads();
    t_entry();
    t_masked();
    t_return(8'h05);
    t_busy_ignore();
    t_return(8'h05);
    t_priority();
    t_return(8'h0F);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule